// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Logging

This peripheral guards a system against a hung processor. Software loads a 24-bit down-counter through a register on an APB slave port. Every qualified tick strobe takes two off the counter. If the counter drops from a nonzero value to zero, the block raises a one-cycle reset request. Software can also force a reset request by writing a self-clearing control bit. The block records which of the two events caused the last request.

Counting runs only while the block is enabled. Three optional pause sources can also stop it: a debug-halt input for each of two processors, and a JTAG-busy input. Each source has its own pause bit, and a source stops the count only when its bit is set and its input is high. Eight 32-bit keep registers give software a place to store state across a soft reset. A hard reset clears everything. A soft reset clears everything except the keep registers and the cause register.

Top module: `wdog_apb_top`

## Requirements
- R1: After a hard reset, the control word at 0x00 reads 0x07000000, and the cause register at 0x08 and every keep register read 0. In the control word, bit 30 is the enable, bits 26, 25 and 24 are the pause bits for CPU1 debug, CPU0 debug and JTAG, and bits 23:0 show the live count.
- R2: Every transfer finishes without wait states: pready is 1 and pslverr is 0. Read data is captured in the setup phase and is valid in the access phase. The reload register at 0x04 reads 0, and any unmapped address reads 0.
- R3: A write to 0x04 loads pwdata[23:0] into the counter on the access edge. A load takes priority over a tick in the same cycle.
- R4: While the block is enabled and not paused, each tick takes 2 off a nonzero count.
- R5: While bit 30 is clear, the count does not change except through a load.
- R6: A pause source stops counting only when its pause bit and its input are both high. A high input whose pause bit is clear has no effect.
- R7: A tick that takes the count from a nonzero value to zero or below leaves the count at 0. It raises reset_req for exactly one cycle in the next cycle and sets the cause register to 1 (bit 0 = timer). Ticks at a count of 0 raise nothing.
- R8: Writing 0x00 with bit 31 set raises a one-cycle reset_req and sets the cause register to 2 (bit 1 = forced). The other control fields are written as usual, and bit 31 always reads 0.
- R9: When a forced trigger and a timer expiry fall in the same cycle, a single reset_req pulse results and the cause register is set to 2.
- R10: A soft reset returns the control word to 0x07000000 and clears the count and reset_req. It leaves the keep registers and the cause register unchanged.
- R11: A hard reset clears the keep registers and the cause register.
- R12: Keep register i sits at address 0x0C + 4*i for i = 0..7, and all 32 bits can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Synchronous active-high reset; keep and cause registers are preserved |
| tick | input | 1 | One-cycle count strobe |
| dbg_cpu0 | input | 1 | Processor 0 is halted in debug |
| dbg_cpu1 | input | 1 | Processor 1 is halted in debug |
| jtag_busy | input | 1 | JTAG is accessing the bus fabric |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (registered) |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume the APB master follows the protocol. Every transfer is one setup cycle followed by one access cycle with address and data held steady, and two accesses never overlap. They also assume that no register write falls in a cycle where either reset is high. The bench drives every transfer through two-phase tasks and places reset pulses only between transfers. Ticks land either between transfers or, for the priority case, deliberately in a write's access cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_CFG    = 'h00;
  localparam int OFS_RELOAD = 'h04;
  localparam int OFS_CAUSE  = 'h08;
  localparam int OFS_KEEP   = 'h0C;

  localparam int BIT_FORCE  = 31;
  localparam int BIT_EN     = 30;
  localparam int BIT_HOLD1  = 26;
  localparam int BIT_HOLD0  = 25;
  localparam int BIT_HOLDJ  = 24;

  typedef struct packed {
    logic en;
    logic hold_cpu1;
    logic hold_cpu0;
    logic hold_jtag;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{en: 1'b0, hold_cpu1: 1'b1, hold_cpu0: 1'b1, hold_jtag: 1'b1};

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_TIMER = 2'b01,
    CAUSE_FORCE = 2'b10
  } cause_e;
endpackage

// File: rtl/wdog_gate.sv
module wdog_gate
  import wdog_pkg::*;
(
  input  logic tick,
  input  cfg_t cfg,
  input  logic dbg_cpu0,
  input  logic dbg_cpu1,
  input  logic jtag_busy,
  output logic tick_ok
);
  logic paused;

  always_comb begin
    paused  = (cfg.hold_cpu1 & dbg_cpu1) | (cfg.hold_cpu0 & dbg_cpu0) | (cfg.hold_jtag & jtag_busy);
    tick_ok = tick & cfg.en & ~paused;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             hard_rst,
  input  logic             soft_rst,
  input  logic             tick_ok,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             force_req,
  output logic [CNT_W-1:0] count_o,
  output logic             reset_req_o,
  output cause_e           cause_o
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] count_q;
  logic             expire;
  cause_e           cause_q;

  assign expire = tick_ok & ~load_wr & (count_q != '0) & (count_q <= STEP_V);

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) begin
      count_q <= '0;
    end else if (load_wr) begin
      count_q <= load_val;
    end else if (tick_ok && count_q != '0) begin
      count_q <= expire ? '0 : count_q - STEP_V;
    end
  end

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) reset_req_o <= 1'b0;
    else                      reset_req_o <= expire | force_req;
  end

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      cause_q <= CAUSE_NONE;
    end else if (!soft_rst) begin
      if (force_req)   cause_q <= CAUSE_FORCE;
      else if (expire) cause_q <= CAUSE_TIMER;
    end
  end

  assign count_o = count_q;
  assign cause_o = cause_q;

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    load_wr |=> (count_q == $past(load_val)));

  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    !load_wr |=> (count_q <= $past(count_q)));

  // R7
  timer_cause_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (expire && !force_req) |=> (reset_req_o && cause_q == CAUSE_TIMER && count_q == '0));

  // R9
  force_cause_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    force_req |=> (reset_req_o && cause_q == CAUSE_FORCE));
endmodule

// File: rtl/wdog_apb_regs.sv
module wdog_apb_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int N_KEEP = 8
) (
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  count_i,
  input  cause_e            cause_i,
  output logic [DATA_W-1:0] prdata,
  output cfg_t              cfg_o,
  output logic              load_wr_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              force_o
);
  localparam int KEEP_STRIDE = DATA_W / 8;

  logic wr_acc, rd_setup, hit_cfg, hit_reload, hit_cause, keep_wr_any;
  logic [N_KEEP-1:0]             keep_hit;
  logic [N_KEEP-1:0][DATA_W-1:0] keep_q;
  logic [DATA_W-1:0]             rd_word;
  cfg_t                          cfg_q;

  assign wr_acc     = psel & penable & pwrite;
  assign rd_setup   = psel & ~penable & ~pwrite;
  assign hit_cfg    = (paddr == ADDR_W'(OFS_CFG));
  assign hit_reload = (paddr == ADDR_W'(OFS_RELOAD));
  assign hit_cause  = (paddr == ADDR_W'(OFS_CAUSE));

  for (genvar g = 0; g < N_KEEP; g++) begin : g_keep_dec
    assign keep_hit[g] = (paddr == ADDR_W'(OFS_KEEP + KEEP_STRIDE * g));
  end

  assign keep_wr_any = wr_acc & (|keep_hit);
  assign load_wr_o   = wr_acc & hit_reload;
  assign load_val_o  = pwdata[CNT_W-1:0];
  assign force_o     = wr_acc & hit_cfg & pwdata[BIT_FORCE];

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) begin
      cfg_q <= CFG_RESET;
    end else if (wr_acc && hit_cfg) begin
      cfg_q.en        <= pwdata[BIT_EN];
      cfg_q.hold_cpu1 <= pwdata[BIT_HOLD1];
      cfg_q.hold_cpu0 <= pwdata[BIT_HOLD0];
      cfg_q.hold_jtag <= pwdata[BIT_HOLDJ];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_KEEP; i++) begin
      if (hard_rst)                  keep_q[i] <= '0;
      else if (wr_acc && keep_hit[i]) keep_q[i] <= pwdata;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_cfg) begin
      rd_word[BIT_EN]    = cfg_q.en;
      rd_word[BIT_HOLD1] = cfg_q.hold_cpu1;
      rd_word[BIT_HOLD0] = cfg_q.hold_cpu0;
      rd_word[BIT_HOLDJ] = cfg_q.hold_jtag;
      rd_word[CNT_W-1:0] = count_i;
    end else if (hit_cause) begin
      rd_word[1:0] = cause_i;
    end else begin
      for (int i = 0; i < N_KEEP; i++)
        if (keep_hit[i]) rd_word = keep_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) prdata <= '0;
    else if (rd_setup)        prdata <= rd_word;
  end

  assign cfg_o = cfg_q;

  // R10
  keep_soft_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (soft_rst && !keep_wr_any) |=> $stable(keep_q));

  // R12
  keep_write_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (wr_acc && keep_hit[0]) |=> (keep_q[0] == $past(pwdata)));
endmodule

// File: rtl/wdog_apb_top.sv
module wdog_apb_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int N_KEEP = 8,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              dbg_cpu0,
  input  logic              dbg_cpu1,
  input  logic              jtag_busy,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              reset_req
);
  cfg_t             cfg;
  logic             tick_ok, load_wr, force_req;
  logic [CNT_W-1:0] load_val, count;
  cause_e           cause;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdog_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .N_KEEP(N_KEEP)) u_regs (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .count_i(count), .cause_i(cause), .prdata(prdata), .cfg_o(cfg),
    .load_wr_o(load_wr), .load_val_o(load_val), .force_o(force_req)
  );

  wdog_gate u_gate (
    .tick(tick), .cfg(cfg), .dbg_cpu0(dbg_cpu0), .dbg_cpu1(dbg_cpu1),
    .jtag_busy(jtag_busy), .tick_ok(tick_ok)
  );

  wdog_core #(.CNT_W(CNT_W), .STEP(STEP)) u_core (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .tick_ok(tick_ok),
    .load_wr(load_wr), .load_val(load_val), .force_req(force_req),
    .count_o(count), .reset_req_o(reset_req), .cause_o(cause)
  );

  // R5
  hold_off_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (!cfg.en && !load_wr) |=> $stable(count));

  // R6
  pause_cpu0_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (cfg.hold_cpu0 && dbg_cpu0 && !load_wr) |=> $stable(count));

  // R10
  soft_cause_chk: assert property (@(posedge clk) disable iff (hard_rst)
    soft_rst |=> ($stable(cause) && !reset_req));
endmodule

// File: tb/wdog_apb_top_test.sv
`timescale 1ns/1ps
module wdog_apb_top_test;
  logic        clk = 1'b0;
  logic        hard_rst = 1'b1, soft_rst = 1'b0, tick = 1'b0;
  logic        dbg_cpu0 = 1'b0, dbg_cpu1 = 1'b0, jtag_busy = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, reset_req;

  int total = 0, bad = 0, pulses = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  wdog_apb_top uut (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .tick(tick),
    .dbg_cpu0(dbg_cpu0), .dbg_cpu1(dbg_cpu1), .jtag_busy(jtag_busy),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr), .reset_req(reset_req)
  );

  // behavioural reference model
  bit          m_en, m_h1, m_h0, m_hj, m_req;
  int          m_cnt, m_cause;
  logic [31:0] m_keep [8];
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] w = 0;
    if (a == 8'h00) w = {1'b0, m_en, 3'b000, m_h1, m_h0, m_hj, 24'(m_cnt)};
    else if (a == 8'h08) w = 32'(m_cause);
    else if (a >= 8'h0C && a < 8'h2C && a[1:0] == 2'b00) w = m_keep[(a - 8'h0C) / 4];
    return w;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (hard_rst || soft_rst) begin
      m_en = 0; m_h1 = 1; m_h0 = 1; m_hj = 1; m_cnt = 0; m_req = 0; m_rd = 0;
      if (hard_rst) begin
        m_cause = 0;
        foreach (m_keep[i]) m_keep[i] = 0;
      end
    end else begin
      bit wr, ff, ft, ok;
      wr = psel && penable && pwrite;
      ft = 0;
      if (psel && !penable && !pwrite) m_rd = m_read(paddr);
      ff = wr && paddr == 8'h00 && pwdata[31];
      ok = tick && m_en && !((m_h1 && dbg_cpu1) || (m_h0 && dbg_cpu0) || (m_hj && jtag_busy));
      if (wr && paddr == 8'h04) m_cnt = int'(pwdata[23:0]);
      else if (ok && m_cnt > 0) begin
        m_cnt = m_cnt - 2;
        if (m_cnt <= 0) begin m_cnt = 0; ft = 1; end
      end
      m_req = ff || ft;
      if (ff) m_cause = 2; else if (ft) m_cause = 1;
      if (wr && paddr == 8'h00) begin
        m_en = pwdata[30]; m_h1 = pwdata[26]; m_h0 = pwdata[25]; m_hj = pwdata[24];
      end
      if (wr && paddr >= 8'h0C && paddr < 8'h2C && paddr[1:0] == 2'b00)
        m_keep[(paddr - 8'h0C) / 4] = pwdata;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      total++;
      if (reset_req !== m_req) begin
        bad++; $display("FAIL R7 reset_req actual=%b expected=%b", reset_req, m_req);
      end
      total++;
      if (prdata !== m_rd) begin
        bad++; $display("FAIL R2 prdata actual=%h expected=%h", prdata, m_rd);
      end
      total++;
      if (pready !== 1'b1 || pslverr !== 1'b0) begin
        bad++; $display("FAIL R2 pready/pslverr actual=%b/%b expected=1/0", pready, pslverr);
      end
      if (reset_req === 1'b1) pulses++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d, input bit t);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; tick = t;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic do_reset(input bit hard);
    @(negedge clk); if (hard) hard_rst = 1; else soft_rst = 1;
    @(negedge clk); hard_rst = 0; soft_rst = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    hard_rst = 0;
    apb_read(8'h00, d); check("R1 cfg reset", d, 32'h0700_0000);
    apb_read(8'h08, d); check("R1 cause reset", d, 32'h0);
    apb_read(8'h18, d); check("R1 keep reset", d, 32'h0);

    for (int i = 0; i < 8; i++) apb_write(8'(8'h0C + 4 * i), 32'hA500_0000 + 32'(i) * 32'h1111, 0);
    for (int i = 0; i < 8; i++) begin
      apb_read(8'(8'h0C + 4 * i), d); check("R12 keep rw", d, 32'hA500_0000 + 32'(i) * 32'h1111);
    end
    apb_read(8'h30, d); check("R2 unmapped", d, 32'h0);

    apb_write(8'h00, 32'h4000_0000, 0);
    apb_write(8'h04, 32'hFF00_000A, 0);
    apb_read(8'h04, d); check("R2 reload reads 0", d, 32'h0);
    apb_read(8'h00, d); check("R3 load", d, 32'h4000_000A);
    pulse_tick(1);
    apb_read(8'h00, d); check("R4 step 2", d, 32'h4000_0008);

    apb_write(8'h00, 32'h0000_0000, 0);
    pulse_tick(2);
    apb_read(8'h00, d); check("R5 disabled hold", d, 32'h0000_0008);

    apb_write(8'h00, 32'h4200_0000, 0);
    dbg_cpu0 = 1; pulse_tick(1); dbg_cpu0 = 0;
    apb_read(8'h00, d); check("R6 pause cpu0", d, 32'h4200_0008);
    dbg_cpu1 = 1; jtag_busy = 1; pulse_tick(1); dbg_cpu1 = 0; jtag_busy = 0;
    apb_read(8'h00, d); check("R6 unselected source", d, 32'h4200_0006);

    pulse_tick(3);
    apb_read(8'h08, d); check("R7 timer cause", d, 32'h1);
    apb_read(8'h00, d); check("R7 saturate", d, 32'h4200_0000);
    pulse_tick(2);
    check("R7 single pulse, no refire", 32'(pulses), 32'd1);

    apb_write(8'h04, 32'd5, 0);
    pulse_tick(2);
    apb_read(8'h00, d); check("R4 odd count", d, 32'h4200_0001);
    pulse_tick(1);
    apb_read(8'h00, d); check("R7 odd expire", d, 32'h4200_0000);
    check("R7 odd pulse", 32'(pulses), 32'd2);

    apb_write(8'h00, 32'hC000_0000, 0);
    apb_read(8'h08, d); check("R8 force cause", d, 32'h2);
    apb_read(8'h00, d); check("R8 bit31 reads 0", d, 32'h4000_0000);
    check("R8 pulse", 32'(pulses), 32'd3);

    apb_write(8'h04, 32'd2, 0);
    pulse_tick(1);
    apb_read(8'h08, d); check("R7 cause back to timer", d, 32'h1);
    apb_write(8'h04, 32'd2, 0);
    apb_write(8'h00, 32'hC000_0000, 1);
    apb_read(8'h08, d); check("R9 force wins", d, 32'h2);
    apb_read(8'h00, d); check("R9 count", d, 32'h4000_0000);
    check("R9 one pulse", 32'(pulses), 32'd5);

    apb_write(8'h04, 32'd100, 0);
    do_reset(0);
    apb_read(8'h00, d); check("R10 cfg after soft", d, 32'h0700_0000);
    apb_read(8'h08, d); check("R10 cause kept", d, 32'h2);
    apb_read(8'h20, d); check("R10 keep kept", d, 32'hA500_5555);

    do_reset(1);
    apb_read(8'h20, d); check("R11 keep cleared", d, 32'h0);
    apb_read(8'h08, d); check("R11 cause cleared", d, 32'h0);

    done = 1;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule